// File: doc/BRIEF.md
# Pulse-Output Interrupt Aggregator

This block gathers a bank of system interrupt request lines and turns them into a small set of host interrupt outputs for a CPU. A request that is high at a clock edge sets a sticky raw status bit for its line. A per-line enable masks that bit into an enabled status view. A programmable table sends each line to one host channel. A host channel is pending while its own enable is set and any enabled status bit routed to it is set.

Each host output is a one-cycle pulse, not a level. The pulse fires only when the channel's gated pending condition goes from 0 to 1. Pending that stays high gives no further pulses. A clear that lands in the same cycle as a still-asserted request leaves the bit latched, and no new pulse comes out. Because the host enable gates the pending condition, servicing code can do three steps to get a fresh pulse for work that is still outstanding: turn the channel off, clear status, and turn the channel on again.

Software uses a single-cycle write strobe and a read strobe on a small word-addressed register port. Reads return data one cycle later.

Top module: `irq_pulse_agg`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) clears all raw status bits, line enables, host enables and `host_irq`, makes `reg_rdata` zero, and points every routing table entry at host channel 0.
- R2: A line whose request is high at a rising edge has its raw status bit set after that edge. The bit stays set after the request drops, until software clears it.
- R3: A read strobe at an edge places the result on `reg_rdata` after that edge, and the result holds until the next read. Read addresses: 0x10+k returns raw status word k (lines 32k..32k+31, lowest line in bit 0). 0x20+k returns the same word ANDed with the line enables. 0x07 returns the host enable vector in the low bits. A line whose enable is 0 never shows in the enabled view.
- R4: Index writes use `reg_wdata[15:0]` as the index. 0x00 sets the raw status bit of that line and 0x01 clears it. 0x02 and 0x03 set and clear a line enable. 0x04 and 0x05 set and clear a host enable.
- R5: A write to 0x06 routes line `reg_wdata[15:0]` to host channel `reg_wdata[31:16]`. From then on, that line's enabled status counts toward that channel only.
- R6: `host_irq[h]` is high for exactly one cycle: the cycle after the edge at which channel h's gated pending condition rises. Pending that stays high produces no further pulse.
- R7: A clear of a line whose request is high in the same cycle leaves the status bit set and produces no pulse.
- R8: Disabling a host channel and enabling it again while a routed, enabled status bit is still set produces a new pulse right after the enabling write.
- R9: A second line becoming enabled and pending on a channel that is already pending produces no pulse. Clearing one of two pending lines on a channel produces no pulse.
- R10: An index write whose line index is not below the line count, or whose host index is not below the host count, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_LINES | System interrupt request lines, sampled each edge |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Write data (index in [15:0], host in [31:16] for routing) |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| host_irq | output | NUM_HOSTS | One-cycle interrupt pulses toward the CPU |

## Verification
Single requests on a routed, enabled line show that a rising pending condition pulses exactly once and that a held condition stays silent. Requests on an unenabled line separate the raw view from the enabled view. A clear that coincides with an active request is set against a clear with no request, which separates the re-latch case (no pulse, bit held) from a true clear that later lets a new pulse through. Two lines sharing one channel, remapping a pending line between channels, a host disable followed by an enable, and out-of-range indices each show whether pulses follow the OR-and-gate rule or leak from single bit changes.

// File: rtl/irq_agg_pkg.sv
// Package: irq_agg_pkg
// Shared register-port widths and word addresses for the interrupt aggregator.
// Assumes a word-addressed port with 6-bit addresses and 32-bit data.
package irq_agg_pkg;
    localparam int REG_ADDR_W  = 6;
    localparam int REG_DATA_W  = 32;
    localparam int IDX_FIELD_W = 16;

    // Index-style write registers
    localparam logic [REG_ADDR_W-1:0] A_STAT_SET  = 6'h00;
    localparam logic [REG_ADDR_W-1:0] A_STAT_CLR  = 6'h01;
    localparam logic [REG_ADDR_W-1:0] A_LEN_SET   = 6'h02;
    localparam logic [REG_ADDR_W-1:0] A_LEN_CLR   = 6'h03;
    localparam logic [REG_ADDR_W-1:0] A_HEN_SET   = 6'h04;
    localparam logic [REG_ADDR_W-1:0] A_HEN_CLR   = 6'h05;
    localparam logic [REG_ADDR_W-1:0] A_ROUTE     = 6'h06;
    // Read views
    localparam logic [REG_ADDR_W-1:0] A_HEN_VIEW  = 6'h07;
    localparam logic [1:0]            WIN_RAW     = 2'b01;  // 0x10..0x1F
    localparam logic [1:0]            WIN_ENB     = 2'b10;  // 0x20..0x2F
endpackage

// File: rtl/irq_reg_port.sv
// Module: irq_reg_port
// Decodes register writes into one-hot set/clear vectors and route-table
// updates, and returns registered read data one cycle after a read strobe.
// Assumes NUM_LINES <= 512 (16 read words) and NUM_HOSTS <= 32.
module irq_reg_port
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_HOSTS = 8,
    localparam int LINE_IDX_W = $clog2(NUM_LINES),
    localparam int HOST_IDX_W = $clog2(NUM_HOSTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [REG_ADDR_W-1:0]  addr,
    input  logic [REG_DATA_W-1:0]  wdata,
    input  logic [NUM_LINES-1:0]   raw_stat,
    input  logic [NUM_LINES-1:0]   enb_stat,
    input  logic [NUM_HOSTS-1:0]   host_en,
    output logic [NUM_LINES-1:0]   stat_set_v,
    output logic [NUM_LINES-1:0]   stat_clr_v,
    output logic [NUM_LINES-1:0]   len_set_v,
    output logic [NUM_LINES-1:0]   len_clr_v,
    output logic [NUM_HOSTS-1:0]   hen_set_v,
    output logic [NUM_HOSTS-1:0]   hen_clr_v,
    output logic                   map_we,
    output logic [LINE_IDX_W-1:0]  map_line,
    output logic [HOST_IDX_W-1:0]  map_host,
    output logic [REG_DATA_W-1:0]  rdata
);
    localparam int NUM_WORDS = (NUM_LINES + REG_DATA_W - 1) / REG_DATA_W;
    localparam int PAD_W     = NUM_WORDS * REG_DATA_W;

    logic [IDX_FIELD_W-1:0] idx_lo;
    logic [IDX_FIELD_W-1:0] idx_hi;
    logic [NUM_LINES-1:0]   line_hot;
    logic [NUM_HOSTS-1:0]   host_hot;
    logic                   line_ok;
    logic                   host_ok;
    logic [PAD_W-1:0]       raw_pad;
    logic [PAD_W-1:0]       enb_pad;
    logic [REG_DATA_W-1:0]  rd_next;

    assign idx_lo = wdata[IDX_FIELD_W-1:0];
    assign idx_hi = wdata[REG_DATA_W-1:IDX_FIELD_W];

    // One-hot index decode; an index past the end matches no entry.
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            line_hot[i] = (idx_lo == IDX_FIELD_W'(i));
        end
        for (int h = 0; h < NUM_HOSTS; h++) begin
            host_hot[h] = (idx_lo == IDX_FIELD_W'(h));
        end
    end

    // Range checks for the route-table write fields.
    assign line_ok = (idx_lo < IDX_FIELD_W'(NUM_LINES));
    assign host_ok = (idx_hi < IDX_FIELD_W'(NUM_HOSTS));

    // Steer the decoded index to the strobe of the addressed register.
    always_comb begin
        stat_set_v = (wr_en && addr == A_STAT_SET) ? line_hot : '0;
        stat_clr_v = (wr_en && addr == A_STAT_CLR) ? line_hot : '0;
        len_set_v  = (wr_en && addr == A_LEN_SET)  ? line_hot : '0;
        len_clr_v  = (wr_en && addr == A_LEN_CLR)  ? line_hot : '0;
        hen_set_v  = (wr_en && addr == A_HEN_SET)  ? host_hot : '0;
        hen_clr_v  = (wr_en && addr == A_HEN_CLR)  ? host_hot : '0;
    end

    // Route-table write request, only for in-range line and host.
    assign map_we   = wr_en && (addr == A_ROUTE) && line_ok && host_ok;
    assign map_line = LINE_IDX_W'(idx_lo);
    assign map_host = HOST_IDX_W'(idx_hi);

    // Zero-pad status vectors to a whole number of read words.
    always_comb begin
        raw_pad = '0;
        enb_pad = '0;
        raw_pad[NUM_LINES-1:0] = raw_stat;
        enb_pad[NUM_LINES-1:0] = enb_stat;
    end

    // Select the read word from the addressed window.
    always_comb begin
        rd_next = '0;
        if (addr == A_HEN_VIEW) begin
            rd_next = REG_DATA_W'(host_en);
        end else begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (addr[3:0] == 4'(w)) begin
                    if (addr[5:4] == WIN_RAW) rd_next = raw_pad[w*REG_DATA_W +: REG_DATA_W];
                    if (addr[5:4] == WIN_ENB) rd_next = enb_pad[w*REG_DATA_W +: REG_DATA_W];
                end
            end
        end
    end

    // Read data register: loads on a read strobe, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    // R3: host enable view appears one cycle after the read strobe
    assert_hen_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_HEN_VIEW) |=> (rdata == REG_DATA_W'($past(host_en))));
endmodule

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank
// Holds the sticky raw status bit and the enable bit of every system line,
// and produces the enabled status view. A request high at an edge wins over a
// software clear in the same cycle, so the bit re-latches.
module irq_status_bank #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req,
    input  logic [NUM_LINES-1:0] stat_set_v,
    input  logic [NUM_LINES-1:0] stat_clr_v,
    input  logic [NUM_LINES-1:0] len_set_v,
    input  logic [NUM_LINES-1:0] len_clr_v,
    output logic [NUM_LINES-1:0] raw_stat,
    output logic [NUM_LINES-1:0] line_en,
    output logic [NUM_LINES-1:0] enb_stat
);
    // Raw status: hardware request or software set, else keep unless cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_stat <= '0;
        else        raw_stat <= req | stat_set_v | (raw_stat & ~stat_clr_v);
    end

    // Line enables: set and clear by index.
    always_ff @(posedge clk) begin
        if (!rst_n) line_en <= '0;
        else        line_en <= len_set_v | (line_en & ~len_clr_v);
    end

    assign enb_stat = raw_stat & line_en;

    // R2: an active request is latched at the edge
    assert_req_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |=> ((raw_stat & $past(req)) == $past(req)));

    // R7: a clear that meets an active request leaves the bit set
    assert_clear_relatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_clr_v & req) != '0) |=>
            ((raw_stat & $past(stat_clr_v & req)) == $past(stat_clr_v & req)));

    // R4: a clear with no competing request drops the bit
    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_clr_v & ~req) != '0) |=> ((raw_stat & $past(stat_clr_v & ~req)) == '0));
endmodule

// File: rtl/irq_host_router.sv
// Module: irq_host_router
// Keeps the line-to-host routing table and ORs, per host channel, the enabled
// status bits routed to it. Assumes map writes arrive already range-checked.
module irq_host_router #(
    parameter int NUM_LINES = 64,
    parameter int NUM_HOSTS = 8,
    localparam int LINE_IDX_W = $clog2(NUM_LINES),
    localparam int HOST_IDX_W = $clog2(NUM_HOSTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  map_we,
    input  logic [LINE_IDX_W-1:0] map_line,
    input  logic [HOST_IDX_W-1:0] map_host,
    input  logic [NUM_LINES-1:0]  enb_stat,
    output logic [NUM_HOSTS-1:0]  host_req
);
    logic [HOST_IDX_W-1:0] route_tbl [NUM_LINES];

    // Routing table: all lines to host 0 at reset, one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) route_tbl[i] <= '0;
        end else if (map_we) begin
            route_tbl[map_line] <= map_host;
        end
    end

    // Per host: OR of enabled status bits whose route selects this host.
    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
        logic [NUM_LINES-1:0] hit;
        always_comb begin
            for (int i = 0; i < NUM_LINES; i++) begin
                hit[i] = enb_stat[i] && (route_tbl[i] == HOST_IDX_W'(h));
            end
        end
        assign host_req[h] = |hit;
    end

    // R5: a route write takes effect at the next edge
    assert_route_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> (route_tbl[$past(map_line)] == $past(map_host)));
endmodule

// File: rtl/irq_pulse_gen.sv
// Module: irq_pulse_gen
// Holds the host channel enables, gates each channel's request with its
// enable, and emits a one-cycle pulse when the gated condition rises.
module irq_pulse_gen #(
    parameter int NUM_HOSTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_HOSTS-1:0] hen_set_v,
    input  logic [NUM_HOSTS-1:0] hen_clr_v,
    input  logic [NUM_HOSTS-1:0] host_req,
    output logic [NUM_HOSTS-1:0] host_en,
    output logic [NUM_HOSTS-1:0] host_irq
);
    logic [NUM_HOSTS-1:0] pend;
    logic [NUM_HOSTS-1:0] pend_q;

    // Host channel enables: set and clear by index.
    always_ff @(posedge clk) begin
        if (!rst_n) host_en <= '0;
        else        host_en <= hen_set_v | (host_en & ~hen_clr_v);
    end

    assign pend = host_en & host_req;

    // Previous gated pending state, for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend;
    end

    assign host_irq = pend & ~pend_q;

    // R6: no pulse lasts past one cycle
    assert_single_cycle_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq != '0) |=> ((host_irq & $past(host_irq)) == '0));

    // R8: enabling an idle channel with a pending request pulses it
    assert_reenable_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hen_set_v & ~host_en & host_req & ~hen_clr_v) != '0) |=>
            ((host_irq & $past(hen_set_v & ~host_en & host_req)) != '0));
endmodule

// File: rtl/irq_pulse_agg.sv
// Module: irq_pulse_agg (top)
// Aggregates NUM_LINES system interrupt requests into NUM_HOSTS pulse
// outputs: sticky status, per-line enables, routing table, gated host
// channels with rise-detected one-cycle pulses, and a simple register port.
module irq_pulse_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_HOSTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  irq_req,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output logic [NUM_HOSTS-1:0]  host_irq
);
    localparam int LINE_IDX_W = $clog2(NUM_LINES);
    localparam int HOST_IDX_W = $clog2(NUM_HOSTS);

    logic [NUM_LINES-1:0]  stat_set_v, stat_clr_v, len_set_v, len_clr_v;
    logic [NUM_HOSTS-1:0]  hen_set_v, hen_clr_v;
    logic                  map_we;
    logic [LINE_IDX_W-1:0] map_line;
    logic [HOST_IDX_W-1:0] map_host;
    logic [NUM_LINES-1:0]  raw_stat, line_en, enb_stat;
    logic [NUM_HOSTS-1:0]  host_req, host_en;

    irq_reg_port #(.NUM_LINES(NUM_LINES), .NUM_HOSTS(NUM_HOSTS)) u_port (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr), .wdata(reg_wdata),
        .raw_stat(raw_stat), .enb_stat(enb_stat), .host_en(host_en),
        .stat_set_v(stat_set_v), .stat_clr_v(stat_clr_v),
        .len_set_v(len_set_v), .len_clr_v(len_clr_v),
        .hen_set_v(hen_set_v), .hen_clr_v(hen_clr_v),
        .map_we(map_we), .map_line(map_line), .map_host(map_host),
        .rdata(reg_rdata)
    );

    irq_status_bank #(.NUM_LINES(NUM_LINES)) u_stat (
        .clk(clk), .rst_n(rst_n), .req(irq_req),
        .stat_set_v(stat_set_v), .stat_clr_v(stat_clr_v),
        .len_set_v(len_set_v), .len_clr_v(len_clr_v),
        .raw_stat(raw_stat), .line_en(line_en), .enb_stat(enb_stat)
    );

    irq_host_router #(.NUM_LINES(NUM_LINES), .NUM_HOSTS(NUM_HOSTS)) u_route (
        .clk(clk), .rst_n(rst_n),
        .map_we(map_we), .map_line(map_line), .map_host(map_host),
        .enb_stat(enb_stat), .host_req(host_req)
    );

    irq_pulse_gen #(.NUM_HOSTS(NUM_HOSTS)) u_pulse (
        .clk(clk), .rst_n(rst_n),
        .hen_set_v(hen_set_v), .hen_clr_v(hen_clr_v),
        .host_req(host_req), .host_en(host_en), .host_irq(host_irq)
    );

    // R3: a line with its enable off never shows in the enabled view
    assert_enabled_view_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((enb_stat & ~line_en) == '0) && ((enb_stat & ~raw_stat) == '0));
endmodule

// File: tb/test_irq_pulse_agg.sv
module test_irq_pulse_agg;
    localparam int NL = 64;
    localparam int NH = 8;

    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_WR   = 2'd1;
    localparam logic [1:0] OP_RD   = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  addr;
        logic [31:0] wdata;
        logic [63:0] req;
        logic [31:0] exp_rd;
        logic [7:0]  exp_irq;
        logic [3:0]  tag;
    } vec_t;

    localparam logic [63:0] L5  = 64'h20;
    localparam logic [63:0] L9  = 64'h200;
    localparam logic [63:0] L40 = 64'h100_0000_0000;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        '{OP_WR,   6'h02, 32'd5,        64'd0, 32'd0,     8'h00, 4'd4},  // R4 enable line 5
        '{OP_WR,   6'h06, 32'h00030005, 64'd0, 32'd0,     8'h00, 4'd5},  // R5 line 5 -> host 3
        '{OP_WR,   6'h04, 32'd3,        64'd0, 32'd0,     8'h00, 4'd8},  // host 3 on, nothing pending
        '{OP_IDLE, 6'h00, 32'd0,        L5,    32'd0,     8'h08, 4'd6},  // R6 rise -> pulse
        '{OP_IDLE, 6'h00, 32'd0,        64'd0, 32'd0,     8'h00, 4'd6},  // R6 held pending, no pulse
        '{OP_RD,   6'h10, 32'd0,        64'd0, 32'h20,    8'h00, 4'd2},  // R2 sticky after drop
        '{OP_RD,   6'h20, 32'd0,        64'd0, 32'h20,    8'h00, 4'd3},  // R3 enabled view
        '{OP_IDLE, 6'h00, 32'd0,        L9,    32'd0,     8'h00, 4'd3},  // R3 line 9 not enabled
        '{OP_RD,   6'h10, 32'd0,        64'd0, 32'h220,   8'h00, 4'd3},
        '{OP_RD,   6'h20, 32'd0,        64'd0, 32'h20,    8'h00, 4'd3},
        '{OP_WR,   6'h01, 32'd5,        L5,    32'd0,     8'h00, 4'd7},  // R7 clear meets request
        '{OP_RD,   6'h10, 32'd0,        64'd0, 32'h220,   8'h00, 4'd7},
        '{OP_WR,   6'h01, 32'd5,        64'd0, 32'd0,     8'h00, 4'd4},  // R4 true clear
        '{OP_RD,   6'h10, 32'd0,        64'd0, 32'h200,   8'h00, 4'd4},
        '{OP_IDLE, 6'h00, 32'd0,        L5,    32'd0,     8'h08, 4'd6},  // R6 new pulse after clear
        '{OP_WR,   6'h05, 32'd3,        64'd0, 32'd0,     8'h00, 4'd8},  // R8 host off
        '{OP_WR,   6'h04, 32'd3,        64'd0, 32'd0,     8'h08, 4'd8},  // R8 host on again -> pulse
        '{OP_RD,   6'h07, 32'd0,        64'd0, 32'h08,    8'h00, 4'd3},
        '{OP_WR,   6'h01, 32'd64,       64'd0, 32'd0,     8'h00, 4'd10}, // R10 index out of range
        '{OP_RD,   6'h10, 32'd0,        64'd0, 32'h220,   8'h00, 4'd10},
        '{OP_WR,   6'h06, 32'h00060028, 64'd0, 32'd0,     8'h00, 4'd5},  // R5 line 40 -> host 6
        '{OP_WR,   6'h02, 32'd40,       64'd0, 32'd0,     8'h00, 4'd4},
        '{OP_WR,   6'h04, 32'd6,        64'd0, 32'd0,     8'h00, 4'd4},
        '{OP_IDLE, 6'h00, 32'd0,        L40,   32'd0,     8'h40, 4'd5},  // R5 only host 6 pulses
        '{OP_RD,   6'h11, 32'd0,        64'd0, 32'h100,   8'h00, 4'd3},
        '{OP_RD,   6'h21, 32'd0,        64'd0, 32'h100,   8'h00, 4'd3},
        '{OP_WR,   6'h06, 32'h00030009, 64'd0, 32'd0,     8'h00, 4'd9},  // R9 line 9 -> busy host 3
        '{OP_WR,   6'h02, 32'd9,        64'd0, 32'd0,     8'h00, 4'd9},  // R9 second line, no pulse
        '{OP_WR,   6'h01, 32'd5,        64'd0, 32'd0,     8'h00, 4'd9},  // R9 one of two cleared
        '{OP_WR,   6'h01, 32'd9,        64'd0, 32'd0,     8'h00, 4'd9},
        '{OP_WR,   6'h00, 32'd9,        64'd0, 32'd0,     8'h08, 4'd4},  // R4 set by index -> pulse
        '{OP_WR,   6'h05, 32'd8,        64'd0, 32'd0,     8'h00, 4'd10}, // R10 host index out of range
        '{OP_RD,   6'h07, 32'd0,        64'd0, 32'h48,    8'h00, 4'd10},
        '{OP_WR,   6'h06, 32'h00030028, 64'd0, 32'd0,     8'h00, 4'd5},  // R5 remap pending line
        '{OP_WR,   6'h01, 32'd9,        64'd0, 32'd0,     8'h00, 4'd9},
        '{OP_WR,   6'h01, 32'd40,       64'd0, 32'd0,     8'h00, 4'd4},
        '{OP_WR,   6'h06, 32'h00060028, 64'd0, 32'd0,     8'h00, 4'd5},
        '{OP_IDLE, 6'h00, 32'd0,        L40,   32'd0,     8'h40, 4'd5},
        '{OP_RD,   6'h21, 32'd0,        64'd0, 32'h100,   8'h00, 4'd3},
        '{OP_RD,   6'h10, 32'd0,        64'd0, 32'h0,     8'h00, 4'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_req = '0;
    logic          reg_wr_en = 1'b0;
    logic          reg_rd_en = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NH-1:0] host_irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    irq_pulse_agg #(.NUM_LINES(NL), .NUM_HOSTS(NH)) i_irq_pulse_agg (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle from a negedge; sample at the following negedge.
    task automatic step(input logic [1:0] op, input logic [5:0] a, input logic [31:0] wd,
                        input logic [63:0] rq, input logic [31:0] exp_rd,
                        input logic [7:0] exp_irq, input string req);
        reg_wr_en = (op == OP_WR);
        reg_rd_en = (op == OP_RD);
        reg_addr  = a;
        reg_wdata = wd;
        irq_req   = rq;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_rd_en = 1'b0;
        irq_req   = '0;
        check32({req, " host_irq"}, 32'(host_irq), 32'(exp_irq));
        if (op == OP_RD) check32({req, " rdata"}, reg_rdata, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check32("R1 reset host_irq", 32'(host_irq), 32'd0);
        check32("R1 reset rdata", reg_rdata, 32'd0);
        step(OP_RD, 6'h07, 32'd0, 64'd0, 32'd0, 8'h00, "R1 host enables");
        step(OP_RD, 6'h10, 32'd0, 64'd0, 32'd0, 8'h00, "R1 raw word0");

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].req,
                 VECS[i].exp_rd, VECS[i].exp_irq,
                 $sformatf("R%0d row%0d", VECS[i].tag, i));
        end

        // R1 reset in mid-run clears state (line 40 status is set here)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check32("R1 reset host_irq mid-run", 32'(host_irq), 32'd0);
        check32("R1 reset rdata mid-run", reg_rdata, 32'd0);
        rst_n = 1'b1;
        step(OP_RD, 6'h11, 32'd0, 64'd0, 32'd0, 8'h00, "R1 raw word1 after reset");
        step(OP_RD, 6'h07, 32'd0, 64'd0, 32'd0, 8'h00, "R1 host enables after reset");
        // R1 route table resets to host 0
        step(OP_WR, 6'h02, 32'd7, 64'd0, 32'd0, 8'h00, "R1 enable line 7");
        step(OP_WR, 6'h04, 32'd0, 64'd0, 32'd0, 8'h00, "R1 enable host 0");
        step(OP_IDLE, 6'h00, 32'd0, 64'h80, 32'd0, 8'h01, "R1 line 7 routes to host 0");
        step(OP_IDLE, 6'h00, 32'd0, 64'h80, 32'd0, 8'h00, "R6 request held, no pulse");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule